// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Collision Rules

This block is a single-clock synchronous RAM with two symmetric ports, A and B. Either port can read or write in any cycle. Each port has an enable, a write select, an address, write data and registered read data. The enable gates both the read and the write. A port that writes also reads in that cycle. A per-port write-mode parameter decides what the writing port presents on its own read data one cycle later.

When both ports are enabled at the same address in one cycle, the block judges whether the combination is legal. Two combinations are accepted. Both ports may read. One port may write and the other read, as long as the writer is in read-first mode. Every other same-address combination raises a collision flag for one cycle. Even in those illegal cases the results stay defined. The non-writing port always sees the word that was stored before the write. When both ports write the same address, port A's data is kept in the array.

Top module: `tdp_ram_collide`

## Requirements
- R1: While reset is low and after it is released, both read data outputs are 0 and the collision flag is 0 until a port loads new data.
- R2: A port with enable 1 and write select 0 presents the stored word at its address on its read data on the next clock edge (one cycle latency).
- R3: A port with enable 0 neither writes nor reads. Its read data holds its value and the array is unchanged, even if write select is 1.
- R4: A port with enable 1 and write select 1 stores its write data at its address, and later reads from either port return it.
- R5: A writing port in read-first mode (mode code 0) presents the word held at that address before the write.
- R6: A writing port in write-first mode (mode code 1) presents its own write data.
- R7: A writing port in no-change mode (mode code 2) keeps its previous read data.
- R8: A port that reads the address the other port writes in the same cycle receives the old word, whatever the modes and whether or not the combination is legal.
- R9: The collision flag is 1 in the cycle after both ports were enabled at one address with at least one writing, unless exactly one wrote and that writer is in read-first mode. A disabled port never takes part in a collision.
- R10: Both ports reading the same address is legal: the flag stays 0 and both return the stored word.
- R11: When both ports write the same address, port A's write data is what the array holds afterwards. This case is always flagged.
- R12: Accesses to different addresses never raise the collision flag, whatever the write selects.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Active-low synchronous reset of outputs |
| a_en | input | 1 | Port A enable |
| a_we | input | 1 | Port A write select |
| a_addr | input | ADDR_W | Port A address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B enable |
| b_we | input | 1 | Port B write select |
| b_addr | input | ADDR_W | Port B address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |
| collide_err | output | 1 | One-cycle flag for an illegal same-address combination |

## Verification
The bench builds two instances on shared stimulus, both with 8-bit data and 16 words. The first has port A in read-first and port B in write-first mode. The second has port A in no-change and port B in read-first mode. Because the modes are paired this way, every same-address write by either port is legal in one instance and illegal in the other. One stimulus stream therefore exercises both the accepted and the flagged branch of each rule. It also shows all three read-back modes next to each other on identical array contents.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;
   // Write-mode codes: what a writing port shows on its own read data.
   typedef enum logic [1:0] {
      WM_READ_FIRST  = 2'd0,
      WM_WRITE_FIRST = 2'd1,
      WM_NO_CHANGE   = 2'd2
   } wmode_e;
endpackage

// File: rtl/tdp_ram_array.sv
module tdp_ram_array #(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              a_wr,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   input  logic              b_wr,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] a_old,
   output logic [DATA_W-1:0] b_old
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] store [DEPTH];

   // Port B is written first so that port A overrides it on a shared address.
   always_ff @(posedge clk) begin
      if (b_wr) store[b_addr] <= b_wdata;
      if (a_wr) store[a_addr] <= a_wdata;
   end

   // Pre-edge contents: both ports observe the word before any write.
   assign a_old = store[a_addr];
   assign b_old = store[b_addr];
endmodule

// File: rtl/tdp_port_out.sv
module tdp_port_out
   import tdp_ram_pkg::*;
#(
   parameter int     DATA_W = 8,
   parameter wmode_e MODE   = WM_READ_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] old_word,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] wr_val;
   logic              wr_load;

   generate
      if (MODE == WM_WRITE_FIRST) begin : g_write_first
         assign wr_val  = wdata;
         assign wr_load = 1'b1;
      end else if (MODE == WM_READ_FIRST) begin : g_read_first
         assign wr_val  = old_word;
         assign wr_load = 1'b1;
      end else begin : g_no_change
         assign wr_val  = old_word;
         assign wr_load = 1'b0;
      end
   endgenerate

   logic              load;
   logic [DATA_W-1:0] nxt;

   always_comb begin
      load = en & (~we | wr_load);
      nxt  = we ? wr_val : old_word;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)    rdata <= '0;
      else if (load) rdata <= nxt;
   end
endmodule

// File: rtl/tdp_collision_chk.sv
module tdp_collision_chk
   import tdp_ram_pkg::*;
#(
   parameter int     ADDR_W = 4,
   parameter wmode_e MODE_A = WM_READ_FIRST,
   parameter wmode_e MODE_B = WM_READ_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   output logic              collide_err
);
   localparam bit A_SAFE = (MODE_A == WM_READ_FIRST);
   localparam bit B_SAFE = (MODE_B == WM_READ_FIRST);

   logic same, bad;

   always_comb begin
      same = a_en & b_en & (a_addr == b_addr);
      bad  = same & ((a_we & b_we) | (a_we & ~A_SAFE) | (b_we & ~B_SAFE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) collide_err <= 1'b0;
      else        collide_err <= bad;
   end
endmodule

// File: rtl/tdp_ram_collide.sv
module tdp_ram_collide
   import tdp_ram_pkg::*;
#(
   parameter int     DATA_W = 8,
   parameter int     ADDR_W = 4,
   parameter wmode_e MODE_A = WM_READ_FIRST,
   parameter wmode_e MODE_B = WM_READ_FIRST
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              a_en,
   input  logic              a_we,
   input  logic [ADDR_W-1:0] a_addr,
   input  logic [DATA_W-1:0] a_wdata,
   output logic [DATA_W-1:0] a_rdata,
   input  logic              b_en,
   input  logic              b_we,
   input  logic [ADDR_W-1:0] b_addr,
   input  logic [DATA_W-1:0] b_wdata,
   output logic [DATA_W-1:0] b_rdata,
   output logic              collide_err
);
   generate
      if (DATA_W < 1)               $error("DATA_W must be at least 1");
      if (ADDR_W < 1 || ADDR_W > 12) $error("ADDR_W must be 1..12");
   endgenerate

   logic [DATA_W-1:0] a_old, b_old;

   tdp_ram_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_array (
      .clk     (clk),
      .a_wr    (a_en & a_we),
      .a_addr  (a_addr),
      .a_wdata (a_wdata),
      .b_wr    (b_en & b_we),
      .b_addr  (b_addr),
      .b_wdata (b_wdata),
      .a_old   (a_old),
      .b_old   (b_old)
   );

   tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_A)) u_out_a (
      .clk(clk), .rst_n(rst_n), .en(a_en), .we(a_we),
      .wdata(a_wdata), .old_word(a_old), .rdata(a_rdata)
   );

   tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
      .clk(clk), .rst_n(rst_n), .en(b_en), .we(b_we),
      .wdata(b_wdata), .old_word(b_old), .rdata(b_rdata)
   );

   tdp_collision_chk #(.ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)) u_coll (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr),
      .collide_err(collide_err)
   );
endmodule

// File: rtl/tdp_ram_collide_sva.sv
module tdp_ram_collide_sva
   import tdp_ram_pkg::*;
#(
   parameter int     DATA_W = 8,
   parameter int     ADDR_W = 4,
   parameter wmode_e MODE_A = WM_READ_FIRST,
   parameter wmode_e MODE_B = WM_READ_FIRST
) (
   input logic              clk,
   input logic              rst_n,
   input logic              a_en,
   input logic              a_we,
   input logic [ADDR_W-1:0] a_addr,
   input logic [DATA_W-1:0] a_wdata,
   input logic [DATA_W-1:0] a_rdata,
   input logic              b_en,
   input logic              b_we,
   input logic [ADDR_W-1:0] b_addr,
   input logic [DATA_W-1:0] b_rdata,
   input logic              collide_err
);
   // R3
   a_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !a_en |=> $stable(a_rdata));
   // R3
   b_idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !b_en |=> $stable(b_rdata));
   // R11
   both_write_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && b_en && a_we && b_we && a_addr == b_addr) |=> collide_err);
   // R10
   both_read_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_en && b_en && !a_we && !b_we) |=> !collide_err);
   // R12
   apart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (a_addr != b_addr) |=> !collide_err);
   // R9
   disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!a_en || !b_en) |=> !collide_err);

   generate
      if (MODE_A == WM_WRITE_FIRST) begin : g_a_wf
         // R6
         a_write_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> a_rdata == $past(a_wdata));
      end
      if (MODE_A == WM_NO_CHANGE) begin : g_a_nc
         // R7
         a_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (a_en && a_we) |=> $stable(a_rdata));
      end
   endgenerate
endmodule

bind tdp_ram_collide tdp_ram_collide_sva #(
   .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MODE_A(MODE_A), .MODE_B(MODE_B)
) u_sva (
   .clk(clk), .rst_n(rst_n),
   .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
   .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_rdata(b_rdata),
   .collide_err(collide_err)
);

// File: tb/tb_tdp_ram_collide.sv
`timescale 1ns/1ps
module tb_tdp_ram_collide;
   import tdp_ram_pkg::*;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;  // 125 MHz

   logic       a_en = 0, a_we = 0, b_en = 0, b_we = 0;
   logic [3:0] a_addr = 0, b_addr = 0;
   logic [7:0] a_wdata = 0, b_wdata = 0;
   logic [7:0] a1, b1, a2, b2;
   logic       e1, e2;

   // dut: A read-first, B write-first. dut_nc: A no-change, B read-first.
   tdp_ram_collide #(.DATA_W(8), .ADDR_W(4), .MODE_A(WM_READ_FIRST), .MODE_B(WM_WRITE_FIRST)) dut (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a1),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b1),
      .collide_err(e1));

   tdp_ram_collide #(.DATA_W(8), .ADDR_W(4), .MODE_A(WM_NO_CHANGE), .MODE_B(WM_READ_FIRST)) dut_nc (
      .clk(clk), .rst_n(rst_n),
      .a_en(a_en), .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a2),
      .b_en(b_en), .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b2),
      .collide_err(e2));

   typedef struct packed {
      logic       ae, awe; logic [3:0] aad; logic [7:0] awd;
      logic       be, bwe; logic [3:0] bad; logic [7:0] bwd;
      logic [7:0] x1a, x1b; logic x1e;
      logic [7:0] x2a, x2b; logic x2e;
      logic [3:0] rq;
   } vec_t;

   localparam int NV = 15;
   // Array preloaded with word k = {k,k}.
   localparam vec_t VECS [NV] = '{
      '{1'b1,1'b0,4'd3,8'h00,  1'b1,1'b0,4'd4,8'h00,  8'h33,8'h44,1'b0, 8'h33,8'h44,1'b0, 4'd2},  // R2 reads
      '{1'b1,1'b0,4'd5,8'h00,  1'b1,1'b0,4'd5,8'h00,  8'h55,8'h55,1'b0, 8'h55,8'h55,1'b0, 4'd10}, // R10 both read
      '{1'b0,1'b1,4'd7,8'hFF,  1'b0,1'b1,4'd7,8'hEE,  8'h55,8'h55,1'b0, 8'h55,8'h55,1'b0, 4'd3},  // R3 disabled
      '{1'b1,1'b0,4'd7,8'h00,  1'b0,1'b0,4'd0,8'h00,  8'h77,8'h55,1'b0, 8'h77,8'h55,1'b0, 4'd3},  // R3 array kept
      '{1'b1,1'b1,4'd6,8'hA6,  1'b1,1'b0,4'd8,8'h00,  8'h66,8'h88,1'b0, 8'h77,8'h88,1'b0, 4'd5},  // R5, R7
      '{1'b1,1'b0,4'd6,8'h00,  1'b1,1'b1,4'd9,8'hB9,  8'hA6,8'hB9,1'b0, 8'hA6,8'h99,1'b0, 4'd6},  // R6, R4
      '{1'b1,1'b1,4'd9,8'hC9,  1'b1,1'b0,4'd9,8'h00,  8'hB9,8'hB9,1'b0, 8'hA6,8'hB9,1'b1, 4'd8},  // R8, R9
      '{1'b1,1'b0,4'd9,8'h00,  1'b1,1'b0,4'd2,8'h00,  8'hC9,8'h22,1'b0, 8'hC9,8'h22,1'b0, 4'd4},  // R4
      '{1'b1,1'b0,4'd2,8'h00,  1'b1,1'b1,4'd2,8'hD2,  8'h22,8'hD2,1'b1, 8'h22,8'h22,1'b0, 4'd9},  // R9, R8
      '{1'b1,1'b1,4'd4,8'hE4,  1'b1,1'b1,4'd4,8'hF4,  8'h44,8'hF4,1'b1, 8'h22,8'h44,1'b1, 4'd11}, // R11 flag
      '{1'b1,1'b0,4'd4,8'h00,  1'b1,1'b0,4'd2,8'h00,  8'hE4,8'hD2,1'b0, 8'hE4,8'hD2,1'b0, 4'd11}, // R11 A wins
      '{1'b1,1'b1,4'd10,8'h5A, 1'b1,1'b1,4'd11,8'h5B, 8'hAA,8'h5B,1'b0, 8'hE4,8'hBB,1'b0, 4'd12}, // R12
      '{1'b1,1'b0,4'd11,8'h00, 1'b1,1'b0,4'd10,8'h00, 8'h5B,8'h5A,1'b0, 8'h5B,8'h5A,1'b0, 4'd4},  // R4
      '{1'b0,1'b1,4'd13,8'h99, 1'b1,1'b1,4'd13,8'h7D, 8'h5B,8'h7D,1'b0, 8'h5B,8'hDD,1'b0, 4'd9},  // R9 disabled A
      '{1'b1,1'b0,4'd13,8'h00, 1'b1,1'b0,4'd13,8'h00, 8'h7D,8'h7D,1'b0, 8'h7D,8'h7D,1'b0, 4'd4}   // R4
   };

   int checks = 0;
   int errors = 0;

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input int rq, input string what);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
      end
   endtask

   task automatic idle();
      a_en = 0; a_we = 0; b_en = 0; b_we = 0;
   endtask

   initial begin
      #(8 * 20000);
      errors++; checks++;
      $display("FAIL R0 watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk(a1, 8'h00, 1, "dut a reset");    chk(b1, 8'h00, 1, "dut b reset");
      chk({7'd0, e1}, 8'h00, 1, "dut flag reset");
      chk(a2, 8'h00, 1, "dut_nc a reset"); chk(b2, 8'h00, 1, "dut_nc b reset");
      chk({7'd0, e2}, 8'h00, 1, "dut_nc flag reset");
      @(negedge clk); rst_n = 1'b1;

      // Preload through port A (read-back unchecked)
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         a_en = 1; a_we = 1; a_addr = 4'(k); a_wdata = {4'(k), 4'(k)};
      end
      @(negedge clk); idle();

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         a_en = VECS[i].ae; a_we = VECS[i].awe; a_addr = VECS[i].aad; a_wdata = VECS[i].awd;
         b_en = VECS[i].be; b_we = VECS[i].bwe; b_addr = VECS[i].bad; b_wdata = VECS[i].bwd;
         @(posedge clk); #1;
         chk(a1, VECS[i].x1a, VECS[i].rq, $sformatf("vec %0d dut a_rdata", i));
         chk(b1, VECS[i].x1b, VECS[i].rq, $sformatf("vec %0d dut b_rdata", i));
         chk({7'd0, e1}, {7'd0, VECS[i].x1e}, VECS[i].rq, $sformatf("vec %0d dut flag", i));
         chk(a2, VECS[i].x2a, VECS[i].rq, $sformatf("vec %0d dut_nc a_rdata", i));
         chk(b2, VECS[i].x2b, VECS[i].rq, $sformatf("vec %0d dut_nc b_rdata", i));
         chk({7'd0, e2}, {7'd0, VECS[i].x2e}, VECS[i].rq, $sformatf("vec %0d dut_nc flag", i));
      end

      // R9 one-cycle flag: a collision followed by idle drops the flag
      @(negedge clk);
      a_en = 1; a_we = 0; a_addr = 4'd1; b_en = 1; b_we = 1; b_addr = 4'd1; b_wdata = 8'h1F;
      @(posedge clk); #1;
      chk({7'd0, e1}, 8'h01, 9, "flag raised (B write-first)");
      chk(a1, 8'h11, 8, "reader sees old word");
      @(negedge clk); idle();
      @(posedge clk); #1;
      chk({7'd0, e1}, 8'h00, 9, "flag lasts one cycle");

      // R1 reset mid-run clears outputs
      @(negedge clk); rst_n = 1'b0;
      @(posedge clk); #1;
      chk(a1, 8'h00, 1, "a cleared by reset");
      chk(b1, 8'h00, 1, "b cleared by reset");
      chk(b2, 8'h00, 1, "dut_nc b cleared by reset");
      @(negedge clk); rst_n = 1'b1;

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule